// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits in the decode stage of an in-order pipeline that can issue two instructions per cycle. In every cycle it looks at the two oldest instructions waiting in the fetch buffer. Each one arrives as a valid bit and a pre-decoded class code. The block decides whether the pair may leave together or whether only the older one issues. The rule is a compatibility table over nine instruction classes. The table depends on order: it is indexed first by the older class and then by the younger class.

The block drives one issue enable per slot. It also returns a consumed count of 0, 1 or 2 to the fetch buffer, and the buffer shifts by that amount. When one instruction issues alone, the fetch buffer moves the held younger instruction into the older slot for the next cycle. A stall input holds everything back. Two memory operations may pair only when an external qualifier flag marks them as a double-word access. Sorting instructions into classes and checking register hazards are handled elsewhere. The outputs are purely combinational from the inputs.

Top module: `pair_issue_unit`

## Requirements
- R1: Class codes are 4 bits wide. 0 is FP operation, 1 is load/store, 2 is integer ALU, 3 is shift/extract/deposit, 4 is may-nullify-successor, 5 is BV/BE branch, 6 is other branch, 7 is FP test/status and 8 is system control. Codes 9 to 15 are undefined and never pair in either slot.
- R2: When the older slot is valid and there is no stall, the older instruction issues. When the older slot is invalid, nothing issues, even if the younger slot is valid.
- R3: The younger instruction issues only if both slots are valid and the ordered pair is allowed. It never issues without the older one.
- R4: An older FP operation pairs with a younger load/store, integer ALU, shift, nullifying, BV/BE or other-branch instruction, and with nothing else.
- R5: An older load/store pairs with a younger FP, integer ALU, shift, nullifying or other-branch instruction. It does not pair with BV/BE.
- R6: An older integer ALU operation pairs with a younger FP, load/store, integer ALU, shift, nullifying, other-branch or FP test/status instruction.
- R7: An older shift/extract/deposit pairs only with a younger FP, load/store, integer ALU or FP test/status instruction.
- R8: An older may-nullify instruction pairs only with a younger FP operation.
- R9: A system-control instruction never pairs, whichever slot it is in. An older BV/BE, other-branch or FP test/status instruction always issues alone.
- R10: A load/store followed by a load/store pairs only when the double-word flag is 1. The flag has no effect on any other class combination.
- R11: While stall is 1, neither slot issues and the consumed count is 0.
- R12: The consumed count equals the number of asserted issue enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oldValid | input | 1 | Older slot holds an instruction |
| oldClass | input | CLS_W | Class code of the older instruction |
| youngValid | input | 1 | Younger slot holds an instruction |
| youngClass | input | CLS_W | Class code of the younger instruction |
| dwPair | input | 1 | The two memory operations form a double-word pair |
| stall | input | 1 | Hold both slots this cycle |
| issueOld | output | 1 | Older instruction issues |
| issueYoung | output | 1 | Younger instruction issues alongside |
| consumed | output | 2 | Number of instructions taken from the fetch buffer |

## Verification
The bench builds the unit with its default 4-bit class code. At that width the full 16 by 16 space of ordered class pairs can be swept, including the seven undefined codes in both slots, with the double-word flag at both values. This sweep covers every cell of the order-dependent table and its reversed counterpart. Random traffic then mixes valid bits, the stall input and the flag to exercise how issue gating interacts with the table.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLS_W   = 4;
  localparam int NUM_CLS = 9;

  // Class codes (R1)
  localparam int C_FLOP  = 0;
  localparam int C_LDST  = 1;
  localparam int C_ALU   = 2;
  localparam int C_SHIFT = 3;
  localparam int C_NULL  = 4;
  localparam int C_BVBE  = 5;
  localparam int C_BR    = 6;
  localparam int C_FTST  = 7;
  localparam int C_SYS   = 8;

  typedef struct packed {
    logic       issueOld;
    logic       issueYoung;
    logic [1:0] taken;
  } issueStrobes_t;

  // Row of the ordered compatibility table: younger classes allowed after 'older'
  function automatic logic [NUM_CLS-1:0] youngMask(input int unsigned older);
    logic [NUM_CLS-1:0] m;
    m = '0;
    case (older)
      C_FLOP: begin
        m[C_LDST] = 1'b1; m[C_ALU] = 1'b1; m[C_SHIFT] = 1'b1;
        m[C_NULL] = 1'b1; m[C_BVBE] = 1'b1; m[C_BR] = 1'b1;
      end
      C_LDST: begin
        m[C_FLOP] = 1'b1; m[C_ALU] = 1'b1; m[C_SHIFT] = 1'b1;
        m[C_NULL] = 1'b1; m[C_BR] = 1'b1;
      end
      C_ALU: begin
        m[C_FLOP] = 1'b1; m[C_LDST] = 1'b1; m[C_ALU] = 1'b1; m[C_SHIFT] = 1'b1;
        m[C_NULL] = 1'b1; m[C_BR] = 1'b1; m[C_FTST] = 1'b1;
      end
      C_SHIFT: begin
        m[C_FLOP] = 1'b1; m[C_LDST] = 1'b1; m[C_ALU] = 1'b1; m[C_FTST] = 1'b1;
      end
      C_NULL: m[C_FLOP] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pair_matrix.sv
module pair_matrix
  import pair_pkg::*;
#(
  parameter int CLS_W = pair_pkg::CLS_W
) (
  input  logic [CLS_W-1:0] oldClass,
  input  logic [CLS_W-1:0] youngClass,
  input  logic             dwPair,
  output logic             compat
);
  logic [NUM_CLS-1:0] rowMask;
  logic [NUM_CLS-1:0] youngHit;
  logic               memPair;

  always_comb rowMask = youngMask(32'(oldClass));

  // one comparator per defined class; undefined younger codes match nothing
  for (genvar k = 0; k < NUM_CLS; k++) begin : g_hit
    assign youngHit[k] = rowMask[k] && (youngClass == CLS_W'(k));
  end

  assign memPair = (oldClass == CLS_W'(C_LDST)) && (youngClass == CLS_W'(C_LDST));
  assign compat  = (|youngHit) || (memPair && dwPair);
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
(
  input  logic          oldValid,
  input  logic          youngValid,
  input  logic          stall,
  input  logic          compat,
  output issueStrobes_t strobes
);
  always_comb begin
    strobes.issueOld   = oldValid && !stall;
    strobes.issueYoung = strobes.issueOld && youngValid && compat;
    strobes.taken      = 2'(strobes.issueOld) + 2'(strobes.issueYoung);
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_pkg::*;
#(
  parameter int CLS_W = pair_pkg::CLS_W
) (
  input  logic             oldValid,
  input  logic [CLS_W-1:0] oldClass,
  input  logic             youngValid,
  input  logic [CLS_W-1:0] youngClass,
  input  logic             dwPair,
  input  logic             stall,
  output logic             issueOld,
  output logic             issueYoung,
  output logic [1:0]       consumed
);
  logic          compat;
  issueStrobes_t strobes;

  pair_matrix #(.CLS_W(CLS_W)) u_matrix (
    .oldClass  (oldClass),
    .youngClass(youngClass),
    .dwPair    (dwPair),
    .compat    (compat)
  );

  pair_ctrl u_ctrl (
    .oldValid  (oldValid),
    .youngValid(youngValid),
    .stall     (stall),
    .compat    (compat),
    .strobes   (strobes)
  );

  assign issueOld   = strobes.issueOld;
  assign issueYoung = strobes.issueYoung;
  assign consumed   = strobes.taken;
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
  import pair_pkg::*;
#(
  parameter int CLS_W = pair_pkg::CLS_W
) (
  input logic             oldValid,
  input logic [CLS_W-1:0] oldClass,
  input logic             youngValid,
  input logic [CLS_W-1:0] youngClass,
  input logic             dwPair,
  input logic             stall,
  input logic             issueOld,
  input logic             issueYoung,
  input logic [1:0]       consumed
);
  always_comb begin
    assert_old_first_R3: assert (!issueYoung || issueOld)
      else $error("younger issued without older");
    assert_young_valid_R3: assert (youngValid || !issueYoung)
      else $error("invalid younger slot issued");
    assert_no_old_R2: assert (oldValid || (!issueOld && !issueYoung))
      else $error("issue with invalid older slot");
    assert_stall_R11: assert (!stall || (!issueOld && !issueYoung && consumed == 2'd0))
      else $error("issue during stall");
    assert_count_R12: assert (consumed == 2'(issueOld) + 2'(issueYoung))
      else $error("consumed count mismatch");
    assert_sys_alone_R9: assert (!issueYoung ||
        (oldClass != CLS_W'(C_SYS) && youngClass != CLS_W'(C_SYS)))
      else $error("system instruction paired");
    assert_mem_pair_R10: assert (!issueYoung || dwPair ||
        !(oldClass == CLS_W'(C_LDST) && youngClass == CLS_W'(C_LDST)))
      else $error("memory pair without qualifier");
  end
endmodule

bind pair_issue_unit pair_issue_check #(.CLS_W(CLS_W)) u_check (
  .oldValid  (oldValid),
  .oldClass  (oldClass),
  .youngValid(youngValid),
  .youngClass(youngClass),
  .dwPair    (dwPair),
  .stall     (stall),
  .issueOld  (issueOld),
  .issueYoung(issueYoung),
  .consumed  (consumed)
);

// File: tb/pair_issue_unit_test.sv
module pair_issue_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic oldValid = 1'b0, youngValid = 1'b0, dwPair = 1'b0, stall = 1'b0;
  logic [W-1:0] oldClass = '0, youngClass = '0;
  logic issueOld, issueYoung;
  logic [1:0] consumed;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_issue_unit #(.CLS_W(W)) uut (
    .oldValid(oldValid), .oldClass(oldClass), .youngValid(youngValid),
    .youngClass(youngClass), .dwPair(dwPair), .stall(stall),
    .issueOld(issueOld), .issueYoung(issueYoung), .consumed(consumed)
  );

  // Independent model of the ordered pairing table
  function automatic bit expPair(input int o, input int y, input bit dw);
    case (o)
      0: return (y == 1 || y == 2 || y == 3 || y == 4 || y == 5 || y == 6);
      1: return (y == 0 || y == 2 || y == 3 || y == 4 || y == 6 || (y == 1 && dw));
      2: return (y == 0 || y == 1 || y == 2 || y == 3 || y == 4 || y == 6 || y == 7);
      3: return (y == 0 || y == 1 || y == 2 || y == 7);
      4: return (y == 0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagFor(input int o);
    case (o)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit v0, input int c0, input bit v1, input int c1,
                       input bit dw, input bit st, input string tag);
    bit e0, e1;
    logic [1:0] ec;
    @(posedge clk);
    oldValid = v0; oldClass = W'(c0); youngValid = v1; youngClass = W'(c1);
    dwPair = dw; stall = st;
    @(negedge clk);
    e0 = v0 && !st;
    e1 = e0 && v1 && expPair(c0, c1, dw);
    ec = 2'(e0) + 2'(e1);
    checks++;
    if (issueOld !== e0 || issueYoung !== e1 || consumed !== ec) begin
      errors++;
      $display("FAIL %s: old=%0d/%0d dw=%0d st=%0d actual issue=%b%b cnt=%0d expected issue=%b%b cnt=%0d",
               tag, c0, c1, dw, st, issueOld, issueYoung, consumed, e0, e1, ec);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state: idle inputs, nothing issues (R2)
    @(negedge clk);
    checks++;
    if (issueOld !== 1'b0 || issueYoung !== 1'b0 || consumed !== 2'd0) begin
      errors++;
      $display("FAIL R2 reset: actual %b%b/%0d expected 00/0", issueOld, issueYoung, consumed);
    end
    check(1, 0, 1, 1, 0, 0, "R1");   // FP then load/store pairs
    check(0, 2, 1, 2, 0, 0, "R2");   // older invalid: nothing
    check(1, 2, 0, 2, 0, 0, "R3");   // younger invalid: one
    check(1, 0, 1, 5, 0, 0, "R4");   // FP + BV/BE pairs
    check(1, 1, 1, 5, 0, 0, "R5");   // load/store + BV/BE alone
    check(1, 5, 1, 1, 0, 0, "R9");   // reversed order alone
    check(1, 2, 1, 7, 0, 0, "R6");
    check(1, 3, 1, 4, 0, 0, "R7");
    check(1, 4, 1, 0, 0, 0, "R8");
    check(1, 4, 1, 2, 0, 0, "R8");
    check(1, 8, 1, 0, 0, 0, "R9");
    check(1, 0, 1, 8, 0, 0, "R9");
    check(1, 12, 1, 0, 0, 0, "R1");  // undefined older code
    check(1, 1, 1, 1, 0, 0, "R10");
    check(1, 1, 1, 1, 1, 0, "R10");
    check(1, 2, 1, 1, 1, 0, "R10");
    check(1, 3, 1, 8, 1, 0, "R10");
    check(1, 2, 1, 2, 0, 1, "R11");
    check(1, 2, 1, 2, 1, 0, "R12");

    // exhaustive ordered sweep with both flag values
    for (int o = 0; o < 16; o++)
      for (int y = 0; y < 16; y++)
        for (int d = 0; d < 2; d++)
          check(1, o, 1, y, d[0], 0, tagFor(o));

    // constrained random mix
    void'($urandom(32'd4711));
    for (int n = 0; n < 2000; n++) begin
      int o, y;
      o = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 9);
      y = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 9);
      check(($urandom % 8) != 0, o, ($urandom % 6) != 0, y,
            $urandom % 2 == 1, ($urandom % 7) == 0, "R12");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule